// File: doc/BRIEF.md
# Reconfigurable Ring Cellular Automaton

This block is a one-dimensional ring of single-bit cells that all advance together. On each step, every cell replaces its value with one bit picked from an 8-entry rule table. The pick uses the three-bit neighbourhood formed by the cell to its left, the cell itself and the cell to its right. The rule table is an ordinary register that can be rewritten at any time, so one array can run any elementary neighbourhood rule without being rebuilt.

A host first writes a rule and loads an initial configuration through a parallel seed port. It then raises the step enable for as many generations as it wants and watches the parallel state output. A registered flag reports global synchronization: every cell holds the same value, and that shared value has flipped on the step just taken. This is the goal condition of the classic firefly synchronization task.

Top module: `ca_ring`

## Requirements
- R1: While reset is high, and in the cycle after it is released, the state output is all zeros and the sync flag is low.
- R2: When seed_we is high at a clock edge, state_out equals the seed_in value sampled at that edge from the next cycle on.
- R3: A step (step_en high, seed_we and rule_we low) sets each cell i to bit k of the rule, where k = 4*left + 2*self + right. Here left is cell i-1 and right is cell i+1, and all cells read the state from before the step.
- R4: The ring wraps: the left neighbour of cell 0 is cell N_CELLS-1, and the right neighbour of cell N_CELLS-1 is cell 0.
- R5: With step_en, seed_we and rule_we all low, state_out and sync_flag hold their values.
- R6: A seed load or a rule load in a cycle blocks the step for that cycle, even when step_en is high. If seed_we and rule_we are high together, both loads take effect.
- R7: A rule written with rule_we applies to every step from the next cycle on. Steps taken before the write use the old rule.
- R8: After a step, sync_flag is high exactly when the state before the step was all equal to a value v and the state after it is all equal to the inverse of v. The flag updates in the same cycle as state_out.
- R9: sync_flag is cleared by any seed or rule load, and by any step that does not meet the R8 condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rule_we | input | 1 | Write rule_in into the rule table |
| rule_in | input | 8 | New rule table; bit k is the next state for neighbourhood value k |
| seed_we | input | 1 | Load seed_in as the cell state |
| seed_in | input | N_CELLS | Initial configuration, bit i for cell i |
| step_en | input | 1 | Advance the array one generation |
| state_out | output | N_CELLS | Current cell states, bit i for cell i |
| sync_flag | output | 1 | Global synchronization reached on the last step |

## Verification
The bench builds the block with its default ring of 56 cells, so the wrap links between cell 0 and cell 55 are exercised at full size. Single-cell seeds sit next to the seam, and shift-left and shift-right rules carry a marker across it in both directions. A rule that maps 000 to 1 and 111 to 0 gives a two-state oscillation, which brings the sync flag within reach in a few steps. A chaotic rule on random seeds covers the general lookup and the flag clearing. A behavioural model in the bench is compared with the state and the flag after every clock.

// File: rtl/ca_pkg.sv
package ca_pkg;
  localparam int NBR_W  = 3;
  localparam int RULE_W = 1 << NBR_W;

  typedef logic [RULE_W-1:0] rule_t;

  // What the array does at the coming clock edge.
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_SEED = 2'd1,
    ACT_RULE = 2'd2,
    ACT_STEP = 2'd3
  } ca_act_e;

  function automatic logic rule_pick(input rule_t r, input logic l,
                                     input logic s, input logic rt);
    logic [NBR_W-1:0] idx;
    idx = {l, s, rt};
    return r[idx];
  endfunction
endpackage

// File: rtl/ca_rule_reg.sv
module ca_rule_reg
  import ca_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  we,
  input  rule_t din,
  output rule_t rule
);
  always_ff @(posedge clk) begin
    if (rst)     rule <= '0;
    else if (we) rule <= din;
  end

  // R7: written value is visible on the next cycle
  p_rule_write_r7: assert property (@(posedge clk) disable iff (rst)
    we |=> rule == $past(din));
endmodule

// File: rtl/ca_cell.sv
module ca_cell
  import ca_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  ca_act_e act,
  input  rule_t   rule,
  input  logic    seed_bit,
  input  logic    left,
  input  logic    right,
  output logic    q,
  output logic    nxt
);
  always_comb nxt = rule_pick(rule, left, q, right);

  always_ff @(posedge clk) begin
    if (rst)                 q <= 1'b0;
    else if (act == ACT_SEED) q <= seed_bit;
    else if (act == ACT_STEP) q <= nxt;
  end
endmodule

// File: rtl/ca_cell_array.sv
module ca_cell_array
  import ca_pkg::*;
#(
  parameter int N_CELLS = 56
) (
  input  logic               clk,
  input  logic               rst,
  input  ca_act_e            act,
  input  rule_t              rule,
  input  logic [N_CELLS-1:0] seed,
  output logic [N_CELLS-1:0] state,
  output logic [N_CELLS-1:0] nxt
);
  localparam int LAST = N_CELLS - 1;

  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    localparam int LI = (i == 0)    ? LAST : i - 1;
    localparam int RI = (i == LAST) ? 0    : i + 1;
    ca_cell u_cell (
      .clk      (clk),
      .rst      (rst),
      .act      (act),
      .rule     (rule),
      .seed_bit (seed[i]),
      .left     (state[LI]),
      .right    (state[RI]),
      .q        (state[i]),
      .nxt      (nxt[i])
    );
  end

  // R5/R6: no step and no seed means every cell keeps its value
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_HOLD || act == ACT_RULE) |=> $stable(state));

  // R2: a seed load lands in one cycle
  p_seed_r2: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_SEED) |=> state == $past(seed));

  // R4: cell 0 reads cell LAST as its left neighbour
  p_wrap_low_r4: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_STEP) |=>
      state[0] == $past(rule[{state[LAST], state[0], state[1]}]));

  // R4: cell LAST reads cell 0 as its right neighbour
  p_wrap_high_r4: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_STEP) |=>
      state[LAST] == $past(rule[{state[LAST-1], state[LAST], state[0]}]));
endmodule

// File: rtl/ca_sync_detect.sv
module ca_sync_detect
  import ca_pkg::*;
#(
  parameter int N_CELLS = 56
) (
  input  logic               clk,
  input  logic               rst,
  input  ca_act_e            act,
  input  logic [N_CELLS-1:0] cur,
  input  logic [N_CELLS-1:0] nxt,
  output logic               flag
);
  logic cur_uniform, nxt_uniform, flipped;

  always_comb begin
    cur_uniform = (&cur) | ~(|cur);
    nxt_uniform = (&nxt) | ~(|nxt);
    flipped     = cur[0] ^ nxt[0];
  end

  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else begin
      case (act)
        ACT_STEP:           flag <= cur_uniform & nxt_uniform & flipped;
        ACT_SEED, ACT_RULE: flag <= 1'b0;
        default:            flag <= flag;
      endcase
    end
  end

  // R8: a raised flag always sees a uniform array
  p_sync_uniform_r8: assert property (@(posedge clk) disable iff (rst)
    flag |-> ((&cur) || !(|cur)));

  // R8: the flag only rises on a step that changed the array
  p_sync_rise_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> cur != $past(cur));

  // R9: loads clear the flag
  p_sync_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_SEED || act == ACT_RULE) |=> !flag);
endmodule

// File: rtl/ca_ring.sv
module ca_ring
  import ca_pkg::*;
#(
  parameter int N_CELLS = 56
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rule_we,
  input  logic [7:0]         rule_in,
  input  logic               seed_we,
  input  logic [N_CELLS-1:0] seed_in,
  input  logic               step_en,
  output logic [N_CELLS-1:0] state_out,
  output logic               sync_flag
);
  ca_act_e            act;
  rule_t              rule;
  logic [N_CELLS-1:0] nxt;

  // Loads win over stepping; a seed load outranks a rule-only cycle.
  always_comb begin
    if (seed_we)      act = ACT_SEED;
    else if (rule_we) act = ACT_RULE;
    else if (step_en) act = ACT_STEP;
    else              act = ACT_HOLD;
  end

  ca_rule_reg u_rule (
    .clk  (clk),
    .rst  (rst),
    .we   (rule_we),
    .din  (rule_in),
    .rule (rule)
  );

  ca_cell_array #(.N_CELLS(N_CELLS)) u_array (
    .clk   (clk),
    .rst   (rst),
    .act   (act),
    .rule  (rule),
    .seed  (seed_in),
    .state (state_out),
    .nxt   (nxt)
  );

  ca_sync_detect #(.N_CELLS(N_CELLS)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .act  (act),
    .cur  (state_out),
    .nxt  (nxt),
    .flag (sync_flag)
  );

  // R6: a rule write blocks a requested step
  p_rule_blocks_step_r6: assert property (@(posedge clk) disable iff (rst)
    (rule_we && !seed_we && step_en) |=> $stable(state_out));

  // R1: first cycle out of reset is clean
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (state_out == '0 && !sync_flag));
endmodule

// File: tb/ca_ring_tb.sv
module ca_ring_tb;
  localparam int N = 56;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         rule_we = 1'b0;
  logic [7:0]   rule_in = '0;
  logic         seed_we = 1'b0;
  logic [N-1:0] seed_in = '0;
  logic         step_en = 1'b0;
  logic [N-1:0] state_out;
  logic         sync_flag;

  int checks = 0;
  int failures = 0;

  logic [N-1:0] m_state = '0;
  logic [7:0]   m_rule = '0;
  logic         m_sync = 1'b0;

  always #10 clk = ~clk;

  ca_ring #(.N_CELLS(N)) u_dut (
    .clk(clk), .rst(rst), .rule_we(rule_we), .rule_in(rule_in),
    .seed_we(seed_we), .seed_in(seed_in), .step_en(step_en),
    .state_out(state_out), .sync_flag(sync_flag)
  );

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog req=all actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic compare(input string tag);
    checks++;
    if (state_out !== m_state) begin
      failures++;
      $display("FAIL %s state actual=%h expected=%h", tag, state_out, m_state);
    end
    checks++;
    if (sync_flag !== m_sync) begin
      failures++;
      $display("FAIL %s sync actual=%b expected=%b", tag, sync_flag, m_sync);
    end
  endtask

  function automatic logic uniform(input logic [N-1:0] v);
    int ones = 0;
    for (int i = 0; i < N; i++) ones += v[i];
    return (ones == 0) || (ones == N);
  endfunction

  // Behavioural model of one clock edge.
  task automatic model_edge(input logic sw, input logic [N-1:0] sd,
                            input logic rw, input logic [7:0] rd, input logic st);
    logic [N-1:0] nx;
    if (sw || rw) begin
      if (sw) m_state = sd;
      if (rw) m_rule = rd;
      m_sync = 1'b0;
    end else if (st) begin
      for (int i = 0; i < N; i++) begin
        int l = (i + N - 1) % N;
        int r = (i + 1) % N;
        int k = 4 * m_state[l] + 2 * m_state[i] + m_state[r];
        nx[i] = m_rule[k];
      end
      m_sync = uniform(m_state) && uniform(nx) && (nx[0] != m_state[0]);
      m_state = nx;
    end
  endtask

  task automatic cyc(input logic sw, input logic [N-1:0] sd, input logic rw,
                     input logic [7:0] rd, input logic st, input string tag);
    seed_we = sw; seed_in = sd; rule_we = rw; rule_in = rd; step_en = st;
    @(posedge clk);
    model_edge(sw, sd, rw, rd, st);
    #5;
    compare(tag);
    @(negedge clk);
  endtask

  function automatic logic [N-1:0] rnd_vec();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = 1'($urandom);
    return v;
  endfunction

  initial begin
    logic [N-1:0] one_hot;
    void'($urandom(32'd566));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #5;
    compare("R1");
    @(negedge clk);

    // R7: rule 30, then seed (R2) and steps (R3)
    cyc(0, '0, 1, 8'h1E, 0, "R7");
    cyc(1, rnd_vec(), 0, '0, 0, "R2");
    for (int s = 0; s < 20; s++) cyc(0, '0, 0, '0, 1, "R3");
    for (int s = 0; s < 3; s++) cyc(0, '0, 0, '0, 0, "R5");

    // R4: shift across the seam in both directions
    one_hot = '0; one_hot[N-1] = 1'b1;
    cyc(0, '0, 1, 8'hF0, 0, "R7");
    cyc(1, one_hot, 0, '0, 0, "R2");
    cyc(0, '0, 0, '0, 1, "R4");
    cyc(0, '0, 0, '0, 1, "R4");
    one_hot = '0; one_hot[0] = 1'b1;
    cyc(0, '0, 1, 8'hAA, 0, "R7");
    cyc(1, one_hot, 0, '0, 0, "R2");
    cyc(0, '0, 0, '0, 1, "R4");
    cyc(0, '0, 0, '0, 1, "R4");

    // R6: loads block a requested step
    cyc(1, rnd_vec(), 0, '0, 1, "R6");
    cyc(0, '0, 1, 8'h96, 1, "R6");
    cyc(1, rnd_vec(), 1, 8'h6E, 1, "R6");
    for (int s = 0; s < 5; s++) cyc(0, '0, 0, '0, 1, "R7");

    // R8: oscillating rule reaches synchronization
    cyc(0, '0, 1, 8'h01, 0, "R9");
    cyc(1, '0, 0, '0, 0, "R2");
    for (int s = 0; s < 4; s++) cyc(0, '0, 0, '0, 1, "R8");
    cyc(0, '0, 0, '0, 0, "R5");
    cyc(0, '0, 0, '0, 0, "R5");
    cyc(1, {N{1'b1}}, 0, '0, 0, "R9");
    cyc(0, '0, 0, '0, 1, "R8");
    cyc(0, '0, 1, 8'h01, 0, "R9");

    // R9: non-flipping step clears the flag
    cyc(0, '0, 0, '0, 1, "R8");
    cyc(0, '0, 0, '0, 1, "R8");
    cyc(0, '0, 1, 8'hFF, 0, "R9");
    cyc(0, '0, 0, '0, 1, "R9");
    cyc(0, '0, 0, '0, 1, "R9");

    // Random mix
    for (int s = 0; s < 200; s++) begin
      int p = $urandom_range(0, 9);
      cyc(p == 0, rnd_vec(), p == 1, 8'($urandom), p > 3, "R3");
    end

    // R1: reset mid-run
    rst = 1'b1;
    @(posedge clk);
    m_state = '0; m_rule = '0; m_sync = 1'b0;
    #5; compare("R1");
    @(negedge clk);
    rst = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule